// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block is a local timer that raises a vector-tagged interrupt after a programmed number of prescaled clock ticks. Software sets the tick rate through a divide code, and it chooses one-shot or periodic operation, an interrupt mask and an interrupt vector through a mode write. It then loads a 32-bit initial count. The count decrements once per prescaled tick. When the count reaches zero, the block emits a single-cycle interrupt pulse that carries the vector number.

In periodic mode the programmed initial count is reloaded at each expiry, so the interrupts arrive at a fixed spacing. A larger initial count spaces them proportionally further apart. In one-shot mode the counter stops at zero. The live counter value can be read at any time.

A write of the initial count restarts the countdown at once, and this write also resets the prescaler phase. A write of zero stops the timer.

Top module: `cdt_timer`

## Requirements
- R1: After reset `cur_count` reads 0, `irq_valid` is low, and no interrupt is raised until an initial count is written.
- R2: With divide code 0 (divide by one), the counter decrements on every clock edge after the load edge. A load of N raises `irq_valid` in the cycle after the N-th edge following the load edge.
- R3: Divide code k (0 to 7) makes one tick every 2^k clock cycles. The first interrupt after loading N follows the N*2^k-th edge after the load edge.
- R4: In periodic mode (`mode_periodic`=1) the counter reloads the initial count at expiry, so `cur_count` never shows 0 while running. An interrupt repeats every N*2^k cycles.
- R5: In one-shot mode (`mode_periodic`=0) exactly one interrupt is raised. After it `cur_count` stays 0 and no further interrupt occurs.
- R6: `irq_vector` carries the vector last written through `mode_vector` when `irq_valid` is high. `irq_valid` is a one-cycle pulse for a single expiry.
- R7: While `mode_mask`=1 no interrupt is delivered, but the counter keeps counting and reloading. After the mask is cleared, interrupts resume.
- R8: A write of `icnt_val` loads `cur_count` at the next edge. It restarts the countdown and the prescaler phase, even in the middle of a countdown.
- R9: Writing an initial count of 0 stops the timer. `cur_count` stays 0 and no interrupt is raised.
- R10: The initial count is unsigned and accepts the full value 0xFFFFFFFF, which then decrements to 0xFFFFFFFE.
- R11: Ten times the initial count gives ten times the interrupt spacing in periodic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_we | input | 1 | Write strobe for the divide code |
| div_code | input | DIV_SEL_W | Divide code k; ticks every 2^k cycles |
| mode_we | input | 1 | Write strobe for mode, mask and vector |
| mode_periodic | input | 1 | 1 selects periodic operation, 0 selects one-shot |
| mode_mask | input | 1 | 1 suppresses interrupt delivery |
| mode_vector | input | VEC_W | Vector number delivered on expiry |
| icnt_we | input | 1 | Write strobe for the initial count |
| icnt_val | input | CNT_W | Initial count value; 0 stops the timer |
| cur_count | output | CNT_W | Live counter value |
| irq_valid | output | 1 | Interrupt pulse |
| irq_vector | output | VEC_W | Vector accompanying the interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit count, an 8-bit vector and a 3-bit divide code. These values bring all eight divisors from 1 to 128 within reach, together with a load of the full all-ones count. Expiry edges are measured per divisor, and periodic spacing is compared across two counts. The cases also cover a mid-countdown reload with a resettled prescaler phase and masked expiries that keep reloading.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   typedef enum logic {
      CDT_ONESHOT  = 1'b0,
      CDT_PERIODIC = 1'b1
   } cdt_mode_e;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NCODE = 1 << SEL_W;
   localparam int PRE_W = NCODE - 1;

   logic [PRE_W-1:0] pre_q;
   logic [NCODE-1:0] tick_by_code;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
   end

   // code k ticks when the low k bits of the phase are all ones
   for (genvar k = 0; k < NCODE; k++) begin : g_code
      if (k == 0) begin : g_every
         assign tick_by_code[k] = 1'b1;
      end else begin : g_div
         assign tick_by_code[k] = &pre_q[k-1:0];
      end
   end

   assign tick = tick_by_code[sel];
endmodule

// File: rtl/cdt_down.sv
module cdt_down #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload_val,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] init_q;
   logic             run_q;

   assign expire = run_q & tick & ~load & (count_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         init_q  <= '0;
         run_q   <= 1'b0;
      end else if (load) begin
         count_q <= load_val;
         init_q  <= load_val;
         run_q   <= (load_val != '0);
      end else if (expire) begin
         if (periodic) begin
            count_q <= init_q;
         end else begin
            count_q <= '0;
            run_q   <= 1'b0;
         end
      end else if (run_q && tick) begin
         count_q <= count_q - ONE;
      end
   end

   assign count      = count_q;
   assign reload_val = init_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
   parameter int CNT_W     = 32,
   parameter int VEC_W     = 8,
   parameter int DIV_SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 div_we,
   input  logic [DIV_SEL_W-1:0] div_code,
   input  logic                 mode_we,
   input  logic                 mode_periodic,
   input  logic                 mode_mask,
   input  logic [VEC_W-1:0]     mode_vector,
   input  logic                 icnt_we,
   input  logic [CNT_W-1:0]     icnt_val,
   output logic [CNT_W-1:0]     cur_count,
   output logic                 irq_valid,
   output logic [VEC_W-1:0]     irq_vector
);
   import cdt_pkg::*;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("cdt_timer: CNT_W out of range");
   end
   if (DIV_SEL_W < 1 || DIV_SEL_W > 4) begin : g_bad_div
      $error("cdt_timer: DIV_SEL_W out of range");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("cdt_timer: VEC_W must be positive");
   end

   logic [DIV_SEL_W-1:0] div_q;
   cdt_mode_e            mode_q;
   logic                 mask_q;
   logic [VEC_W-1:0]     vec_q;
   logic                 tick;
   logic                 expire;
   logic [CNT_W-1:0]     init_val;
   logic                 irq_q;
   logic [VEC_W-1:0]     irq_vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         mode_q <= CDT_ONESHOT;
         mask_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         if (div_we) div_q <= div_code;
         if (mode_we) begin
            mode_q <= mode_periodic ? CDT_PERIODIC : CDT_ONESHOT;
            mask_q <= mode_mask;
            vec_q  <= mode_vector;
         end
      end
   end

   cdt_prescale #(.SEL_W(DIV_SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (icnt_we | div_we),
      .sel     (div_q),
      .tick    (tick)
   );

   cdt_down #(.CNT_W(CNT_W)) u_down (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (icnt_we),
      .load_val   (icnt_val),
      .tick       (tick),
      .periodic   (mode_q == CDT_PERIODIC),
      .count      (cur_count),
      .reload_val (init_val),
      .expire     (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_vec_q <= '0;
      end else begin
         irq_q <= expire & ~mask_q;
         if (expire) irq_vec_q <= vec_q;
      end
   end

   assign irq_valid  = irq_q;
   assign irq_vector = irq_vec_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             icnt_we,
   input logic [CNT_W-1:0] icnt_val,
   input logic [CNT_W-1:0] cur_count,
   input logic             irq_valid,
   input logic [VEC_W-1:0] irq_vector,
   input logic             mask_q,
   input logic [VEC_W-1:0] vec_q,
   input cdt_pkg::cdt_mode_e mode_q,
   input logic [CNT_W-1:0] init_val
);
   import cdt_pkg::*;

   a_r8_load_now: assert property (@(posedge clk) disable iff (!rst_n)
      icnt_we |=> cur_count == $past(icnt_val));

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!icnt_we && cur_count > 1) |=>
         (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1));

   a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!icnt_we && cur_count == '0) |=> cur_count == '0);

   a_r6_vector_tag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_vector == $past(vec_q));

   a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !$past(mask_q));

   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> cur_count == (($past(mode_q) == CDT_PERIODIC) ? $past(init_val) : '0));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .icnt_we    (icnt_we),
   .icnt_val   (icnt_val),
   .cur_count  (cur_count),
   .irq_valid  (irq_valid),
   .irq_vector (irq_vector),
   .mask_q     (mask_q),
   .vec_q      (vec_q),
   .mode_q     (mode_q),
   .init_val   (init_val)
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
   localparam int CNT_W = 32;
   localparam int VEC_W = 8;
   localparam int DSW   = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             div_we = 1'b0;
   logic [DSW-1:0]   div_code = '0;
   logic             mode_we = 1'b0;
   logic             mode_periodic = 1'b0;
   logic             mode_mask = 1'b0;
   logic [VEC_W-1:0] mode_vector = '0;
   logic             icnt_we = 1'b0;
   logic [CNT_W-1:0] icnt_val = '0;
   logic [CNT_W-1:0] cur_count;
   logic             irq_valid;
   logic [VEC_W-1:0] irq_vector;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cdt_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W), .DIV_SEL_W(DSW)) u_cdt_timer (
      .clk(clk), .rst_n(rst_n),
      .div_we(div_we), .div_code(div_code),
      .mode_we(mode_we), .mode_periodic(mode_periodic), .mode_mask(mode_mask),
      .mode_vector(mode_vector),
      .icnt_we(icnt_we), .icnt_val(icnt_val),
      .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_div(input int k);
      @(negedge clk); div_we = 1'b1; div_code = DSW'(k);
      @(negedge clk); div_we = 1'b0;
   endtask

   task automatic wr_mode(input bit per, input bit msk, input logic [VEC_W-1:0] vec);
      @(negedge clk); mode_we = 1'b1; mode_periodic = per; mode_mask = msk; mode_vector = vec;
      @(negedge clk); mode_we = 1'b0;
   endtask

   // returns at the negedge just after the load edge (index 0)
   task automatic wr_cnt(input logic [CNT_W-1:0] v);
      @(negedge clk); icnt_we = 1'b1; icnt_val = v;
      @(negedge clk); icnt_we = 1'b0;
   endtask

   task automatic wait_irq(input int max, output int idx);
      bit found = 1'b0;
      idx = 0;
      for (int i = 1; i <= max; i++) begin
         if (!found) begin
            @(negedge clk);
            if (irq_valid) begin idx = i; found = 1'b1; end
         end
      end
   endtask

   task automatic count_irqs(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq_valid) cnt++;
      end
   endtask

   task automatic t_reset;
      int n;
      chk("R1 count after reset", cur_count, 0);
      chk("R1 irq after reset", irq_valid, 0);
      count_irqs(50, n);
      chk("R1 no irq without load", n, 0);
   endtask

   task automatic t_div1;
      int idx, n;
      wr_div(0);
      wr_mode(1'b0, 1'b0, 8'h21);
      wr_cnt(5);
      chk("R8 loaded value", cur_count, 5);
      @(negedge clk);
      chk("R2 decrement each edge", cur_count, 4);
      wait_irq(20, idx);
      chk("R2 expiry edge", idx + 1, 5);
      chk("R6 vector", irq_vector, 8'h21);
      @(negedge clk);
      chk("R6 single pulse", irq_valid, 0);
      chk("R5 count stays zero", cur_count, 0);
      count_irqs(40, n);
      chk("R5 no second irq", n, 0);
      chk("R5 still zero", cur_count, 0);
   endtask

   task automatic t_divisors;
      int idx;
      for (int k = 0; k < 8; k++) begin
         wr_div(k);
         wr_mode(1'b0, 1'b0, 8'(8'h40 + k));
         wr_cnt(3);
         wait_irq(500, idx);
         chk($sformatf("R3 divisor code %0d expiry", k), idx, 3 << k);
         chk("R6 vector per code", irq_vector, 8'h40 + k);
      end
   endtask

   task automatic t_periodic;
      int a, b, c, p1, p2;
      bit saw_zero = 1'b0;
      wr_div(1);
      wr_mode(1'b1, 1'b0, 8'h7);
      wr_cnt(4);
      wait_irq(100, a);
      chk("R4 first periodic expiry", a, 8);
      chk("R4 reloaded count", cur_count, 4);
      wait_irq(100, b);
      chk("R4 second spacing", b, 8);
      wait_irq(100, c);
      chk("R4 third spacing", c, 8);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (cur_count == 0) saw_zero = 1'b1;
      end
      chk("R4 never shows zero", saw_zero, 0);
      wr_div(0);
      wr_cnt(3);
      wait_irq(100, a);
      wait_irq(100, p1);
      wr_cnt(30);
      wait_irq(200, a);
      wait_irq(200, p2);
      chk("R11 spacing scales x10", p2, 10 * p1);
      wr_cnt(0);
   endtask

   task automatic t_mask;
      int n, idx;
      wr_div(0);
      wr_mode(1'b1, 1'b1, 8'h33);
      wr_cnt(6);
      repeat (5) @(negedge clk);
      chk("R7 counting while masked", cur_count, 1);
      @(negedge clk);
      chk("R7 masked no pulse", irq_valid, 0);
      chk("R7 reload while masked", cur_count, 6);
      @(negedge clk);
      chk("R7 keeps running", cur_count, 5);
      count_irqs(30, n);
      chk("R7 no irq while masked", n, 0);
      wr_mode(1'b1, 1'b0, 8'h34);
      wait_irq(20, idx);
      chk("R7 irq after unmask", idx != 0, 1);
      chk("R6 updated vector", irq_vector, 8'h34);
      wr_cnt(0);
   endtask

   task automatic t_restart;
      int idx;
      wr_div(2);
      wr_mode(1'b0, 1'b0, 8'h55);
      wr_cnt(10);
      repeat (13) @(negedge clk);
      chk("R3 divide by 4 progress", cur_count, 7);
      wr_cnt(2);
      chk("R8 restart value", cur_count, 2);
      wait_irq(50, idx);
      chk("R8 restart expiry with fresh phase", idx, 8);
   endtask

   task automatic t_zero;
      int n;
      wr_div(0);
      wr_mode(1'b1, 1'b0, 8'h9);
      wr_cnt(5);
      repeat (3) @(negedge clk);
      wr_cnt(0);
      chk("R9 zero write count", cur_count, 0);
      count_irqs(60, n);
      chk("R9 no irq after stop", n, 0);
      chk("R9 count stays zero", cur_count, 0);
   endtask

   task automatic t_max;
      wr_div(0);
      wr_mode(1'b0, 1'b0, 8'h1);
      wr_cnt(32'hFFFF_FFFF);
      chk("R10 full count loads", cur_count, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R10 full count decrements", cur_count, 32'hFFFF_FFFE);
      wr_cnt(0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div1();
      t_divisors();
      t_periodic();
      t_mask();
      t_restart();
      t_zero();
      t_max();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule